// File: doc/BRIEF.md
# Flash FIFO Bulk Transfer Controller

This block sits between a host register bus and a flash-side agent. It moves blocks of 32-bit words through one shared FIFO. The host reaches the FIFO through a single data-port register. To read, the host loads a flash word address and then writes the control register with a word count and the read-mode flag. The controller clears the FIFO and fetches the words from consecutive flash addresses, raising a busy bit while it works. The host then pops the words from the data port, oldest first, and ends the burst by writing zero to the control register.

To write, the host checks the free-space field in the control register and pushes up to that many words into the data port. The flash-side agent drains them from the FIFO head. A byte-enable bus lets the host send a trailing partial word whose unused bytes are stored as zero.

Flash reads are only allowed while the host owns the flash. Ownership is a request bit with a grant status. The grant is withheld while the agent is in the middle of its own access.

Top module: `flash_burst_ctrl`

## Requirements
- R1: After reset the control register (index 0) reads with free space equal to DEPTH in bits [27:16] and zero elsewhere. The address register (index 1) reads 0 and the ownership register (index 3) reads 0.
- R2: In the ownership register, bit 0 is the request and bit 1 is the grant. Grant rises one cycle after the request is set, provided `agent_busy` is low; it stays low while `agent_busy` is high. Grant falls one cycle after the request is cleared.
- R3: A control write with bit 10 set is ignored as a burst start while the grant is low. Busy stays 0 and the FIFO contents are untouched.
- R4: A granted control write with bit 10 set and a nonzero count in bits [9:0] empties the FIFO and sets busy (bit 11). It fetches the words from flash addresses starting at the address register and counting up by one. Busy clears once every word is in the FIFO.
- R5: Each read of the data port (index 2) returns the FIFO head and removes it, in fetch order. The free-space field tracks DEPTH minus the number of stored words.
- R6: A burst with count 0 fetches nothing and busy never sets. A count above DEPTH fetches exactly DEPTH words.
- R7: Writing zero to the control register clears the stored count, the read-mode flag and the overflow bit, and aborts a burst in progress. It does not empty the FIFO.
- R8: A data-port write while idle with free space pushes one word. Each byte lane whose `bus_be` bit is 0 is stored as zero.
- R9: A data-port write while the FIFO is full or a burst is busy is dropped and sets the sticky overflow bit 31.
- R10: `agent_word_valid` is high when the FIFO holds words and no burst is busy. `agent_pop` then removes the head, except in a cycle where the host pops, which takes priority.
- R11: A data-port read of an empty FIFO returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index: 0 control, 1 address, 2 data port, 3 ownership |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for data-port pushes |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| fl_rd_en | output | 1 | Flash word read request |
| fl_rd_addr | output | AW | Flash word address |
| fl_rd_data | input | 32 | Flash word, returned the cycle after the request |
| agent_busy | input | 1 | Flash-side agent is mid-access |
| agent_word_valid | output | 1 | FIFO head available to the agent |
| agent_word | output | 32 | FIFO head word |
| agent_pop | input | 1 | Agent removes the FIFO head |

## Verification
The assertions assume that the flash returns exactly one word in the cycle after each `fl_rd_en` pulse. They also assume `bus_sel` is a single-cycle strobe with no overlapping accesses. The bench's flash model answers every request with a registered read one cycle later, so it never stalls. Its bus tasks assert each access for exactly one clock and release it before the next access starts. The bench raises `agent_busy` only around the ownership request and drops it before any burst begins.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
    localparam int DW = 32;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_ADDR = 2'd1,
        REG_DATA = 2'd2,
        REG_OWN  = 2'd3
    } reg_sel_e;

    // control register layout
    localparam int CNT_W    = 10;
    localparam int MODE_BIT = 10;
    localparam int BUSY_BIT = 11;
    localparam int FREE_LSB = 16;
    localparam int FREE_W   = 12;
    localparam int OVF_BIT  = 31;

    // ownership register layout
    localparam int REQ_BIT = 0;
    localparam int GNT_BIT = 1;
endpackage

// File: rtl/fbc_owner.sv
module fbc_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic req_val,
    input  logic agent_busy,
    output logic req_o,
    output logic grant_o
);
    typedef struct packed {
        logic req;
        logic gnt;
    } own_t;

    own_t own_d, own_q;

    always_comb begin
        own_d     = own_q;
        own_d.req = req_wr ? req_val : own_q.req;
        if (!own_q.req) begin
            own_d.gnt = 1'b0;
        end else begin
            own_d.gnt = own_q.gnt | ~agent_busy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= '0;
        end else begin
            own_q <= own_d;
        end
    end

    assign req_o   = own_q.req;
    assign grant_o = own_q.gnt;
endmodule

// File: rtl/fbc_fifo.sv
module fbc_fifo #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            pop,
    output logic [DW-1:0]   head,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            empty
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNTW-1:0]  cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (p_q.cnt == CNTW'(DEPTH));
    assign empty   = (p_q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        p_d = p_q;
        if (flush) begin
            p_d = '0;
        end else begin
            if (do_push) p_d.wr_ptr = bump(p_q.wr_ptr);
            if (do_pop)  p_d.rd_ptr = bump(p_q.rd_ptr);
            case ({do_push, do_pop})
                2'b10:   p_d.cnt = p_q.cnt + 1'b1;
                2'b01:   p_d.cnt = p_q.cnt - 1'b1;
                default: p_d.cnt = p_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[p_q.wr_ptr] <= push_data;
        end
    end

    assign head  = mem[p_q.rd_ptr];
    assign count = p_q.cnt;
endmodule

// File: rtl/fbc_reader.sv
module fbc_reader #(
    parameter int DEPTH = 512,
    parameter int AW    = 24,
    parameter int CW    = 10,
    parameter int DW    = 32,
    localparam int RW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] start_cnt,
    input  logic          abort,
    output logic          fl_rd_en,
    output logic [AW-1:0] fl_rd_addr,
    input  logic [DW-1:0] fl_rd_data,
    output logic          fill_push,
    output logic [DW-1:0] fill_data,
    output logic          busy
);
    typedef struct packed {
        logic          busy;
        logic          inflight;
        logic [RW-1:0] rem;
        logic [AW-1:0] addr;
    } rd_t;

    rd_t r_d, r_q;
    logic [RW-1:0] eff_cnt;

    // a burst never asks for more words than the FIFO holds
    always_comb begin
        if (32'(start_cnt) > DEPTH) begin
            eff_cnt = RW'(DEPTH);
        end else begin
            eff_cnt = RW'(start_cnt);
        end
    end

    assign fl_rd_en   = r_q.busy && (r_q.rem != '0);
    assign fl_rd_addr = r_q.addr;
    assign fill_push  = r_q.inflight;
    assign fill_data  = fl_rd_data;
    assign busy       = r_q.busy;

    always_comb begin
        r_d = r_q;
        if (abort) begin
            r_d.busy     = 1'b0;
            r_d.inflight = 1'b0;
            r_d.rem      = '0;
        end else if (start) begin
            r_d.busy     = 1'b1;
            r_d.inflight = 1'b0;
            r_d.rem      = eff_cnt;
            r_d.addr     = start_addr;
        end else begin
            r_d.inflight = fl_rd_en;
            if (fl_rd_en) begin
                r_d.rem  = r_q.rem - 1'b1;
                r_d.addr = r_q.addr + 1'b1;
            end
            if (r_q.busy && (r_q.rem == '0) && !r_q.inflight) begin
                r_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/flash_burst_ctrl.sv
module flash_burst_ctrl
    import fbc_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = 24,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic [3:0]    bus_be,
    output logic [31:0]   bus_rdata,
    output logic          fl_rd_en,
    output logic [AW-1:0] fl_rd_addr,
    input  logic [31:0]   fl_rd_data,
    input  logic          agent_busy,
    output logic          agent_word_valid,
    output logic [31:0]   agent_word,
    input  logic          agent_pop
);
    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] cnt;
        logic             mode;
        logic             ovf;
        logic [DW-1:0]    rdata;
    } top_t;

    top_t t_d, t_q;

    logic wr_ctrl, wr_addr, wr_data, wr_own, rd_acc, rd_data;
    logic ctrl_zero, start, host_push_ok, host_push_drop, host_pop, agent_pop_eff;
    logic req, grant, rd_busy, fill_push;
    logic [DW-1:0] fill_data, masked_wdata, head;
    logic [CNTW-1:0] fifo_count;
    logic fifo_full, fifo_empty;
    logic [FREE_W-1:0] free;
    logic [DW-1:0] ctrl_word;

    // register decode
    assign wr_ctrl = bus_sel && bus_we && (bus_addr == REG_CTRL);
    assign wr_addr = bus_sel && bus_we && (bus_addr == REG_ADDR);
    assign wr_data = bus_sel && bus_we && (bus_addr == REG_DATA);
    assign wr_own  = bus_sel && bus_we && (bus_addr == REG_OWN);
    assign rd_acc  = bus_sel && !bus_we;
    assign rd_data = rd_acc && (bus_addr == REG_DATA);

    assign ctrl_zero = wr_ctrl && (bus_wdata == '0);
    assign start     = wr_ctrl && bus_wdata[MODE_BIT] && (bus_wdata[CNT_W-1:0] != '0)
                       && grant && !rd_busy;

    assign host_push_ok   = wr_data && !fifo_full && !rd_busy;
    assign host_push_drop = wr_data && (fifo_full || rd_busy);
    assign host_pop       = rd_data && !fifo_empty;

    assign agent_word_valid = !fifo_empty && !rd_busy;
    assign agent_word       = head;
    assign agent_pop_eff    = agent_pop && agent_word_valid && !host_pop;

    // byte lanes left disabled are stored as zero
    for (genvar b = 0; b < DW / 8; b++) begin : g_lane
        assign masked_wdata[8*b +: 8] = bus_be[b] ? bus_wdata[8*b +: 8] : 8'h00;
    end

    assign free = FREE_W'(DEPTH) - FREE_W'(fifo_count);

    always_comb begin
        ctrl_word                       = '0;
        ctrl_word[CNT_W-1:0]            = t_q.cnt;
        ctrl_word[MODE_BIT]             = t_q.mode;
        ctrl_word[BUSY_BIT]             = rd_busy;
        ctrl_word[FREE_LSB +: FREE_W]   = free;
        ctrl_word[OVF_BIT]              = t_q.ovf;
    end

    always_comb begin
        t_d = t_q;
        if (wr_addr) t_d.addr = bus_wdata[AW-1:0];
        if (wr_ctrl) begin
            t_d.cnt  = bus_wdata[CNT_W-1:0];
            t_d.mode = bus_wdata[MODE_BIT];
        end
        if (ctrl_zero) begin
            t_d.ovf = 1'b0;
        end else if (host_push_drop) begin
            t_d.ovf = 1'b1;
        end
        if (rd_acc) begin
            case (reg_sel_e'(bus_addr))
                REG_CTRL: t_d.rdata = ctrl_word;
                REG_ADDR: t_d.rdata = DW'(t_q.addr);
                REG_DATA: t_d.rdata = fifo_empty ? '0 : head;
                default: begin
                    t_d.rdata          = '0;
                    t_d.rdata[REQ_BIT] = req;
                    t_d.rdata[GNT_BIT] = grant;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign bus_rdata = t_q.rdata;

    fbc_owner u_owner (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_wr     (wr_own),
        .req_val    (bus_wdata[REQ_BIT]),
        .agent_busy (agent_busy),
        .req_o      (req),
        .grant_o    (grant)
    );

    fbc_reader #(.DEPTH(DEPTH), .AW(AW), .CW(CNT_W), .DW(DW)) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (t_q.addr),
        .start_cnt  (bus_wdata[CNT_W-1:0]),
        .abort      (ctrl_zero),
        .fl_rd_en   (fl_rd_en),
        .fl_rd_addr (fl_rd_addr),
        .fl_rd_data (fl_rd_data),
        .fill_push  (fill_push),
        .fill_data  (fill_data),
        .busy       (rd_busy)
    );

    fbc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start),
        .push      (fill_push | host_push_ok),
        .push_data (fill_push ? fill_data : masked_wdata),
        .pop       (host_pop | agent_pop_eff),
        .head      (head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker
    import fbc_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int CNTW  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              agent_busy,
    input logic              req,
    input logic              grant,
    input logic              busy,
    input logic              ovf,
    input logic [CNTW-1:0]   fifo_count,
    input logic [FREE_W-1:0] free,
    input logic              fl_rd_en
);
    p_grant_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !grant);

    p_grant_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> ($past(req) && !$past(agent_busy)));

    p_busy_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(grant));

    p_fetch_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_en |-> busy);

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNTW'(DEPTH));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == REG_DATA && free == '0) |=> ovf);

    p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(bus_sel && bus_we && bus_addr == REG_CTRL && bus_wdata == '0));
endmodule

bind flash_burst_ctrl fbc_checker #(.DEPTH(DEPTH), .CNTW(CNTW)) u_fbc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .agent_busy (agent_busy),
    .req        (req),
    .grant      (grant),
    .busy       (rd_busy),
    .ovf        (t_q.ovf),
    .fifo_count (fifo_count),
    .free       (free),
    .fl_rd_en   (fl_rd_en)
);

// File: tb/test_flash_burst_ctrl.sv
`timescale 1ns/1ps
module test_flash_burst_ctrl;
    localparam int DEPTH = 512;
    localparam int AW    = 24;
    localparam int WDOG  = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [3:0]    bus_be = 4'hF;
    logic [31:0]   bus_rdata;
    logic          fl_rd_en;
    logic [AW-1:0] fl_rd_addr;
    logic [31:0]   fl_rd_data = '0;
    logic          agent_busy = 1'b0;
    logic          agent_word_valid;
    logic [31:0]   agent_word;
    logic          agent_pop = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       sb_tag = "";
    logic        sb_mark = 1'b0;
    logic        mon_arm = 1'b0;

    always #5 clk = ~clk;

    flash_burst_ctrl #(.DEPTH(DEPTH), .AW(AW)) i_flash_burst_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .fl_rd_en(fl_rd_en), .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
        .agent_busy(agent_busy), .agent_word_valid(agent_word_valid),
        .agent_word(agent_word), .agent_pop(agent_pop)
    );

    function automatic logic [31:0] fpat(input logic [AW-1:0] a);
        return (32'(a) * 32'h0000_9E37) ^ 32'h5A5A_0000;
    endfunction

    // flash model: registered word read, one cycle latency
    always @(posedge clk) begin
        if (fl_rd_en) fl_rd_data <= fpat(fl_rd_addr);
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    // scoreboard driver: queue the expected word, then pop the data port
    task automatic sb_pop(input logic [31:0] exp, input string tag);
        logic [31:0] dummy;
        exp_q.push_back(exp);
        sb_tag  = tag;
        sb_mark = 1'b1;
        bus_rd(2'd2, dummy);
        sb_mark = 1'b0;
    endtask

    // scoreboard monitor
    always @(posedge clk) mon_arm <= bus_sel && !bus_we && bus_addr == 2'd2 && sb_mark;
    always @(negedge clk) begin
        if (mon_arm) begin
            if (exp_q.size() == 0) begin
                check({sb_tag, " unexpected pop"}, bus_rdata, 32'hx);
            end else begin
                check(sb_tag, bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        int n = 0;
        do begin
            bus_rd(2'd0, v);
            n++;
        end while (v[11] && n < 3000);
        check({tag, " busy clears"}, 32'(v[11]), 32'd0);
    endtask

    function automatic logic [31:0] ctrl(input int free, input int cnt, input bit mode,
                                         input bit ovf);
        return (32'(ovf) << 31) | (32'(free) << 16) | (32'(mode) << 10) | 32'(cnt);
    endfunction

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(2'd0, v); check("R1 ctrl", v, ctrl(DEPTH, 0, 0, 0));
        bus_rd(2'd1, v); check("R1 addr", v, 32'd0);
        bus_rd(2'd3, v); check("R1 own", v, 32'd0);

        // R3 burst without grant is ignored
        bus_wr(2'd1, 32'h100);
        bus_wr(2'd0, 32'h408);
        repeat (4) @(negedge clk);
        bus_rd(2'd0, v); check("R3 ctrl no burst", v, ctrl(DEPTH, 8, 1, 0));
        bus_rd(2'd2, v); check("R3 fifo empty", v, 32'd0);
        bus_wr(2'd0, 32'h0);

        // R2 grant withheld while agent busy
        agent_busy = 1'b1;
        bus_wr(2'd3, 32'h1);
        repeat (3) @(negedge clk);
        bus_rd(2'd3, v); check("R2 withheld", v, 32'h1);
        agent_busy = 1'b0;
        @(negedge clk);
        bus_rd(2'd3, v); check("R2 granted", v, 32'h3);
        // R2 withdrawal one cycle after clear, then re-grant one cycle after set
        bus_wr(2'd3, 32'h0);
        bus_rd(2'd3, v); check("R2 grant lingers 1 cycle", v, 32'h2);
        bus_rd(2'd3, v); check("R2 grant dropped", v, 32'h0);
        bus_wr(2'd3, 32'h1);
        bus_rd(2'd3, v); check("R2 grant not yet", v, 32'h1);
        bus_rd(2'd3, v); check("R2 grant after 1 cycle", v, 32'h3);

        // R4 burst of 8 words
        bus_wr(2'd1, 32'h100);
        bus_wr(2'd0, 32'h408);
        bus_rd(2'd0, v); check("R4 busy set", 32'(v[11]), 32'd1);
        wait_idle("R4");
        bus_rd(2'd0, v); check("R4 ctrl after fetch", v, ctrl(DEPTH - 8, 8, 1, 0));
        for (int i = 0; i < 8; i++) sb_pop(fpat(AW'(32'h100 + i)), "R5 pop order");
        bus_rd(2'd0, v); check("R5 free restored", v, ctrl(DEPTH, 8, 1, 0));
        // R11 empty pop
        bus_rd(2'd2, v); check("R11 empty pop", v, 32'd0);
        bus_rd(2'd0, v); check("R11 state unchanged", v, ctrl(DEPTH, 8, 1, 0));
        // R7 zero write clears fields
        bus_wr(2'd0, 32'h0);
        bus_rd(2'd0, v); check("R7 ctrl cleared", v, ctrl(DEPTH, 0, 0, 0));

        // R6 count zero
        bus_wr(2'd0, 32'h400);
        repeat (3) @(negedge clk);
        bus_rd(2'd0, v); check("R6 zero count", v, ctrl(DEPTH, 0, 1, 0));
        bus_wr(2'd0, 32'h0);
        // R6 clamp 600 -> DEPTH
        bus_wr(2'd1, 32'h2000);
        bus_wr(2'd0, 32'h658);
        wait_idle("R6");
        bus_rd(2'd0, v); check("R6 clamped fill", v, ctrl(0, 600, 1, 0));
        for (int i = 0; i < DEPTH; i++) sb_pop(fpat(AW'(32'h2000 + i)), "R6 clamp data");
        bus_wr(2'd0, 32'h0);

        // R7 abort right after start
        bus_wr(2'd1, 32'h300);
        bus_wr(2'd0, 32'h464);
        bus_wr(2'd0, 32'h0);
        repeat (3) @(negedge clk);
        bus_rd(2'd0, v); check("R7 abort", v, ctrl(DEPTH, 0, 0, 0));

        // R8 pushes with byte lanes
        bus_wr(2'd2, 32'h1111_2222);
        bus_wr(2'd2, 32'h3333_4444);
        bus_wr(2'd2, 32'hDEAD_BEEF, 4'h3);
        bus_rd(2'd0, v); check("R8 free after push", v, ctrl(DEPTH - 3, 0, 0, 0));
        // R10 agent side
        check("R10 valid", 32'(agent_word_valid), 32'd1);
        check("R10 head", agent_word, 32'h1111_2222);
        agent_pop = 1'b1;
        @(negedge clk);
        agent_pop = 1'b0;
        check("R10 agent popped", agent_word, 32'h3333_4444);
        agent_pop = 1'b1;
        sb_pop(32'h3333_4444, "R10 host priority");
        agent_pop = 1'b0;
        check("R10 agent held off", agent_word, 32'h0000_BEEF);
        sb_pop(32'h0000_BEEF, "R8 padded word");
        check("R10 empty not valid", 32'(agent_word_valid), 32'd0);

        // R9 overflow when full
        for (int i = 0; i < DEPTH; i++) bus_wr(2'd2, 32'h1000 + i);
        bus_rd(2'd0, v); check("R9 full", v, ctrl(0, 0, 0, 0));
        bus_wr(2'd2, 32'hFFFF_FFFF);
        bus_rd(2'd0, v); check("R9 ovf set", v, ctrl(0, 0, 0, 1));
        bus_wr(2'd0, 32'h0);
        bus_rd(2'd0, v); check("R7 ovf cleared", v, ctrl(0, 0, 0, 0));
        sb_pop(32'h1000, "R9 dropped word absent");
        // R9 push while busy
        bus_wr(2'd1, 32'h40);
        bus_wr(2'd0, 32'h658);
        bus_wr(2'd2, 32'h7777_7777);
        wait_idle("R9");
        bus_rd(2'd0, v); check("R9 ovf while busy", v, ctrl(0, 600, 1, 1));
        sb_pop(fpat(AW'(32'h40)), "R9 burst data intact");
        bus_wr(2'd0, 32'h0);

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule